// File: doc/BRIEF.md
# Selectable video downscaler

This block shrinks a raster video stream by a fixed ratio, 1920x1080 down to 1280x720 with the default parameters. Source pixels arrive one per transfer in raster order on a valid/ready input. Resized pixels leave one per transfer in raster order on a valid/ready output. A one-bit input chooses how each output pixel is formed. Bilinear mode weights the four source pixels around the output's fixed-point source position. Nearest mode rounds that position to a single source pixel. Both modes run through the same multiply-and-sum datapath.

Source rows are written into two row banks built from inferred RAM. Each bank is split into even and odd columns, so one read cycle returns the full 2x2 neighbourhood. The block fills rows until both rows needed by the current output line are complete. It then stops taking input while it emits that output line. Rows that no output line uses are still consumed, and the rows left after the last output line are drained before the next frame begins. Frame alignment comes from counting pixels only; no start-of-frame marker is used.

Top module: `scl_downscaler`

## Requirements
- R1: Each frame consumes exactly SRC_W*SRC_H input pixels (this includes trailing source rows that no output uses) and produces exactly DST_W*DST_H output pixels in raster order. After the frame the block is idle with in_ready high and out_valid low.
- R2: An input pixel is taken only at a rising clock edge where in_valid and in_ready are both high. Data presented while in_valid is low has no effect on any output.
- R3: An output pixel is transferred only at a rising edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid stays high and out_pixel stays unchanged.
- R4: Output pixel (ox, oy) maps to the source position ox*STEPX and oy*STEPY, where STEPX = floor(SRC_W*256/DST_W) and STEPY = floor(SRC_H*256/DST_H). These are fixed-point values with 8 fractional bits. The integer part x0 (or y0) names the left (or top) neighbour, and the low 8 bits are the fraction fx (or fy).
- R5: With alg_nearest = 0 (bilinear), each 8-bit channel is (c00*(256-fx)*(256-fy) + c01*fx*(256-fy) + c10*(256-fx)*fy + c11*fx*fy + 32768) >> 16. Here c00 = (x0, y0), c01 = (x0+1, y0), c10 = (x0, y0+1) and c11 = (x0+1, y0+1). The channels are bits [23:16], [15:8] and [7:0], and each is computed independently.
- R6: With alg_nearest = 1 (nearest), the output equals source pixel (x0 + (fx >= 128), y0 + (fy >= 128)). A fraction of exactly one half rounds up.
- R7: The mode is sampled together with the first input pixel of each frame. Changing alg_nearest later in the same frame has no effect on that frame's output.
- R8: in_ready is low from the edge that completes the second needed source row until the last pixel of that output line has been transferred. out_valid and in_ready are never high in the same cycle.
- R9: No output pixel appears until both source rows y0 and y0+1 of the current output line are complete. With only the first source row delivered, out_valid stays low and in_ready stays high.
- R10: After a synchronous active-high reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alg_nearest | input | 1 | 0 = bilinear, 1 = nearest; sampled at the first pixel of each frame |
| in_pixel | input | 24 | Source pixel, R in [23:16], G in [15:8], B in [7:0] |
| in_valid | input | 1 | Source pixel present |
| in_ready | output | 1 | Block can take a source pixel |
| out_pixel | output | 24 | Resized pixel, same channel layout |
| out_valid | output | 1 | Resized pixel present |
| out_ready | input | 1 | Downstream can take a resized pixel |

## Verification
The hardest situation to reach from the ports is the stall point inside a frame. This is the exact cycle where the second needed row completes and the block must stop taking input while no output has appeared yet. The bench reaches it by delivering the first source row, pausing, and checking that nothing comes out. It then delivers the second row and checks that in_ready has dropped. The reduced bench geometry, 12x11 to 8x5, is chosen so that vertical fractions take several distinct values, horizontal fractions hit exactly one half, and a trailing source row must be drained. Mode flips in the middle of a frame show that the sampled mode stays fixed.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // One RGB pixel, 8 bits per channel, red in the top byte.
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Controller phases: take rows, present read address, form pixel,
  // hold pixel for downstream, swallow unused trailing rows.
  typedef enum logic [2:0] {
    S_FILL,
    S_RD,
    S_CALC,
    S_HOLD,
    S_DRAIN
  } phase_t;

endpackage

// File: rtl/scl_line_ram.sv
module scl_line_ram #(
  parameter int DEPTH = 960,
  parameter int W     = 24,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port RAM with a registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/scl_coord.sv
module scl_coord #(
  parameter int SRC  = 1920,
  parameter int DST  = 1280,
  parameter int FRAC = 8,
  parameter int IW   = $clog2(SRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  output logic [IW-1:0]   idx,
  output logic [FRAC-1:0] frac
);

  localparam int STEP = (SRC << FRAC) / DST;
  localparam int AW   = IW + FRAC;

  logic [AW-1:0] acc;

  // Fixed-point source position: restarts on clr, grows by STEP on adv.
  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (adv)    acc <= acc + AW'(STEP);
  end

  assign idx  = acc[AW-1:FRAC];
  assign frac = acc[FRAC-1:0];

  // R4: the right/lower neighbour of the pair must lie inside the source.
  p_pair_inside_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) + 1) < SRC);

endmodule

// File: rtl/scl_blend.sv
module scl_blend
  import scl_pkg::*;
#(
  parameter int FRAC = 8
) (
  input  rgb_t          p00,
  input  rgb_t          p01,
  input  rgb_t          p10,
  input  rgb_t          p11,
  input  logic [FRAC:0] wx,
  input  logic [FRAC:0] wy,
  output rgb_t          q
);

  localparam int            ACCW = 2 * FRAC + 8;
  localparam logic [FRAC:0] ONE  = (FRAC+1)'(1) << FRAC;

  // Four-tap weighted sum with round-half-up; weights sum to ONE*ONE.
  function automatic logic [7:0] mix4(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c, input logic [7:0] d,
                                      input logic [FRAC:0] hx, input logic [FRAC:0] hy);
    logic [ACCW-1:0] ix, iy, jx, jy, s;
    jx = ACCW'(hx);
    jy = ACCW'(hy);
    ix = ACCW'(ONE - hx);
    iy = ACCW'(ONE - hy);
    s  = ACCW'(a) * ix * iy + ACCW'(b) * jx * iy
       + ACCW'(c) * ix * jy + ACCW'(d) * jx * jy
       + (ACCW'(1) << (2 * FRAC - 1));
    return 8'(s >> (2 * FRAC));
  endfunction

  logic [2:0][7:0] c00, c01, c10, c11, cq;

  assign c00 = p00;
  assign c01 = p01;
  assign c10 = p10;
  assign c11 = p11;

  for (genvar k = 0; k < 3; k++) begin : g_chan
    assign cq[k] = mix4(c00[k], c01[k], c10[k], c11[k], wx, wy);
  end

  assign q = cq;

endmodule

// File: rtl/scl_downscaler.sv
module scl_downscaler
  import scl_pkg::*;
#(
  parameter int SRC_W = 1920,
  parameter int SRC_H = 1080,
  parameter int DST_W = 1280,
  parameter int DST_H = 720,
  parameter int FRAC  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        alg_nearest,
  input  logic [23:0] in_pixel,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [23:0] out_pixel,
  output logic        out_valid,
  input  logic        out_ready
);

  localparam int XW   = $clog2(SRC_W);
  localparam int IYW  = $clog2(SRC_H);
  localparam int YW   = $clog2(SRC_H + 1);
  localparam int HALF = SRC_W / 2;
  localparam int HAW  = $clog2(HALF);
  localparam int OXW  = $clog2(DST_W);
  localparam int OYW  = $clog2(DST_H);
  localparam logic [FRAC:0] ONE = (FRAC+1)'(1) << FRAC;

  phase_t         state;
  logic [XW-1:0]  in_x;
  logic [YW-1:0]  rows_done;
  logic [OXW-1:0] ox;
  logic [OYW-1:0] oy;
  logic           mode_q;

  // Named events shared by control and assertions.
  logic accept, row_end, frame_first, fill_done, drain_done;
  logic out_fire, line_out_done, frame_out_done;

  logic [XW-1:0]   x0;
  logic [FRAC-1:0] fx;
  logic [IYW-1:0]  y0;
  logic [FRAC-1:0] fy;
  logic [YW:0]     need;

  assign in_ready       = (state == S_FILL) || (state == S_DRAIN);
  assign accept         = in_valid && in_ready;
  assign row_end        = accept && (in_x == XW'(SRC_W - 1));
  assign frame_first    = accept && (state == S_FILL) && (rows_done == '0) && (in_x == '0);
  assign need           = (YW+1)'(y0) + (YW+1)'(2);
  assign fill_done      = row_end && (state == S_FILL)
                          && (((YW+1)'(rows_done) + (YW+1)'(1)) == need);
  assign drain_done     = row_end && (state == S_DRAIN) && (rows_done == YW'(SRC_H - 1));
  assign out_fire       = out_valid && out_ready;
  assign line_out_done  = out_fire && (ox == OXW'(DST_W - 1));
  assign frame_out_done = line_out_done && (oy == OYW'(DST_H - 1));

  // Source coordinate generators, one per axis.
  scl_coord #(.SRC(SRC_W), .DST(DST_W), .FRAC(FRAC), .IW(XW)) u_cx (
    .clk (clk), .rst (rst), .clr (line_out_done),
    .adv (out_fire && !line_out_done), .idx (x0), .frac (fx));

  scl_coord #(.SRC(SRC_H), .DST(DST_H), .FRAC(FRAC), .IW(IYW)) u_cy (
    .clk (clk), .rst (rst), .clr (frame_out_done),
    .adv (line_out_done && !frame_out_done), .idx (y0), .frac (fy));

  // Line storage: bank = source row parity, half = column parity.
  logic [HAW-1:0] ev_addr, od_addr;
  rgb_t           rd [2][2];

  assign od_addr = x0[HAW:1];
  assign ev_addr = x0[HAW:1] + HAW'(x0[0]);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar c = 0; c < 2; c++) begin : g_half
      scl_line_ram #(.DEPTH(HALF), .W(24), .AW(HAW)) u_ram (
        .clk   (clk),
        .we    (accept && (rows_done[0] == 1'(b)) && (in_x[0] == 1'(c))),
        .waddr (in_x[HAW:1]),
        .wdata (in_pixel),
        .raddr ((c == 0) ? ev_addr : od_addr),
        .rdata (rd[b][c]));
    end
  end

  // Neighbourhood selection: top row sits in bank y0[0].
  rgb_t p00, p01, p10, p11, mixed;
  logic tb, bb;
  assign tb  = y0[0];
  assign bb  = ~y0[0];
  assign p00 = x0[0] ? rd[tb][1] : rd[tb][0];
  assign p01 = x0[0] ? rd[tb][0] : rd[tb][1];
  assign p10 = x0[0] ? rd[bb][1] : rd[bb][0];
  assign p11 = x0[0] ? rd[bb][0] : rd[bb][1];

  // Nearest mode reuses the blend with all-or-nothing weights.
  logic [FRAC:0] wx, wy;
  assign wx = mode_q ? (fx[FRAC-1] ? ONE : '0) : {1'b0, fx};
  assign wy = mode_q ? (fy[FRAC-1] ? ONE : '0) : {1'b0, fy};

  scl_blend #(.FRAC(FRAC)) u_blend (
    .p00 (p00), .p01 (p01), .p10 (p10), .p11 (p11),
    .wx (wx), .wy (wy), .q (mixed));

  // Input counters.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_x      <= '0;
      rows_done <= '0;
      mode_q    <= 1'b0;
    end else begin
      if (accept) in_x <= row_end ? '0 : in_x + XW'(1);
      if (drain_done || (frame_out_done && rows_done == YW'(SRC_H)))
        rows_done <= '0;
      else if (row_end)
        rows_done <= rows_done + YW'(1);
      if (frame_first) mode_q <= alg_nearest;
    end
  end

  // Output counters, phase control and output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_FILL;
      ox        <= '0;
      oy        <= '0;
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      if (line_out_done) begin
        ox <= '0;
        oy <= frame_out_done ? '0 : oy + OYW'(1);
      end else if (out_fire) begin
        ox <= ox + OXW'(1);
      end
      case (state)
        S_FILL:  if (fill_done) state <= S_RD;
        S_RD:    state <= S_CALC;
        S_CALC: begin
          out_pixel <= mixed;
          out_valid <= 1'b1;
          state     <= S_HOLD;
        end
        S_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          if (frame_out_done)
            state <= (rows_done == YW'(SRC_H)) ? S_FILL : S_DRAIN;
          else if (line_out_done)
            state <= S_FILL;
          else
            state <= S_RD;
        end
        S_DRAIN: if (drain_done) state <= S_FILL;
        default: state <= S_FILL;
      endcase
    end
  end

  // R8: input is never offered while a resized pixel is pending.
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R3: a stalled output pixel is held unchanged.
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

  // R9: a read is only issued once both needed rows are stored.
  p_rows_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD) |-> ((YW+1)'(rows_done) >= need));

  // R7: the sampled mode moves only with the first pixel of a frame.
  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_first |=> $stable(mode_q));

endmodule

// File: tb/scl_downscaler_tb.sv
module scl_downscaler_tb;

  localparam int SW = 12, SH = 11, DW = 8, DH = 5;
  localparam int NIN = SW * SH, NOUT = DW * DH;
  localparam int STX = (SW * 256) / DW;
  localparam int STY = (SH * 256) / DH;

  // Vector table: mode, pattern seed, input gap, ready pattern, flip index.
  localparam int NV = 6;
  localparam int V_MODE [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int V_SEED [NV] = '{1, 2, 3, 4, 5, 6};
  localparam int V_GAP  [NV] = '{0, 0, 1, 2, 0, 0};
  localparam int V_RDY  [NV] = '{15, 15, 5, 3, 8, 15};
  localparam int V_FLIP [NV] = '{-1, -1, -1, -1, 30, 50};

  logic        clk = 1'b0, rst = 1'b1, alg_nearest = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [23:0] in_pixel = '0;
  logic        in_ready, out_valid;
  logic [23:0] out_pixel;

  always #2 clk = ~clk;

  scl_downscaler #(.SRC_W(SW), .SRC_H(SH), .DST_W(DW), .DST_H(DH)) u_dut (
    .clk (clk), .rst (rst), .alg_nearest (alg_nearest),
    .in_pixel (in_pixel), .in_valid (in_valid), .in_ready (in_ready),
    .out_pixel (out_pixel), .out_valid (out_valid), .out_ready (out_ready));

  int          n_run = 0, n_fail = 0, n_got = 0;
  bit          clash = 0;
  logic [23:0] got [NOUT];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pix(input int x, input int y, input int seed);
    int r, g, b;
    r = (x * 37 + y * 11 + seed * 29) % 256;
    g = (x * 5 + y * 53 + seed * 3) % 256;
    b = (x * x * 3 + y * 7 + seed * 71) % 256;
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic int chan(input logic [23:0] p, input int k);
    return (p >> (8 * k)) & 255;
  endfunction

  // Reference model straight from R4, R5 and R6.
  function automatic logic [23:0] model(input int ox, input int oy, input bit nearest,
                                        input int seed);
    int x0, y0, fx, fy, v;
    logic [23:0] res;
    x0 = (ox * STX) / 256;  fx = (ox * STX) % 256;
    y0 = (oy * STY) / 256;  fy = (oy * STY) % 256;
    if (nearest) return pix(x0 + (fx >= 128 ? 1 : 0), y0 + (fy >= 128 ? 1 : 0), seed);
    res = '0;
    for (int k = 0; k < 3; k++) begin
      v = chan(pix(x0, y0, seed), k) * (256 - fx) * (256 - fy)
        + chan(pix(x0 + 1, y0, seed), k) * fx * (256 - fy)
        + chan(pix(x0, y0 + 1, seed), k) * (256 - fx) * fy
        + chan(pix(x0 + 1, y0 + 1, seed), k) * fx * fy + 32768;
      res = res | (24'(v >> 16) << (8 * k));
    end
    return res;
  endfunction

  task automatic send(input int seed, input int lo, input int hi, input int gap,
                      input int flip_at, input bit nearest);
    for (int i = lo; i < hi; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_pixel = 24'h5A5A5A;
      end
      @(negedge clk);
      if (i == 0) alg_nearest = nearest;
      if (i == flip_at) alg_nearest = ~nearest;
      in_valid = 1'b1;
      in_pixel = pix(i % SW, i / SW, seed);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input int n, input int rdy);
    int          cyc;
    bit          held;
    logic [23:0] hv;
    cyc = 0; held = 0; hv = '0; n_got = 0; clash = 0;
    while (n_got < n) begin
      @(negedge clk);
      if (out_valid && in_ready) clash = 1;
      if (held) check(out_valid && out_pixel == hv, "R3", "held pixel", out_pixel, hv);
      held = 0;
      out_ready = rdy[cyc % 4];
      cyc++;
      if (out_valid) begin
        if (out_ready) begin
          got[n_got] = out_pixel;
          n_got++;
        end else begin
          held = 1;
          hv   = out_pixel;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic verify(input int seed, input bit nearest, input string req);
    for (int k = 0; k < NOUT; k++)
      check(got[k] == model(k % DW, k / DW, nearest, seed), req,
            $sformatf("pixel %0d", k), got[k], model(k % DW, k / DW, nearest, seed));
  endtask

  task automatic idle_check();
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R1", "idle after frame",
          {in_ready, out_valid}, 2'b10);
    check(clash == 0, "R8", "in_ready with out_valid", clash, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

    // Directed: stall point of the first output line (R9, R8).
    send(9, 0, SW, 0, -1, 1'b0);
    repeat (20) @(negedge clk);
    check(out_valid == 1'b0, "R9", "no output with one row", out_valid, 0);
    check(in_ready == 1'b1, "R9", "still filling with one row", in_ready, 1);
    send(9, SW, 2 * SW, 0, -1, 1'b0);
    check(in_ready == 1'b0, "R8", "input stalled after second row", in_ready, 0);
    fork
      send(9, 2 * SW, NIN, 0, -1, 1'b0);
      collect(NOUT, 15);
    join
    verify(9, 1'b0, "R5 R4");
    idle_check();

    // Table walk: modes, input gaps (R2), ready patterns (R3), mode flips (R7).
    for (int v = 0; v < NV; v++) begin
      fork
        send(V_SEED[v], 0, NIN, V_GAP[v], V_FLIP[v], V_MODE[v] != 0);
        collect(NOUT, V_RDY[v]);
      join
      if (V_FLIP[v] >= 0)      verify(V_SEED[v], V_MODE[v] != 0, "R7");
      else if (V_GAP[v] > 0)   verify(V_SEED[v], V_MODE[v] != 0, "R2");
      else if (V_MODE[v] != 0) verify(V_SEED[v], 1'b1, "R6 R4");
      else                     verify(V_SEED[v], 1'b0, "R5 R4");
      idle_check();
    end

    // Reset again mid-idle.
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(in_ready && !out_valid, "R10", "state after second reset",
          {in_ready, out_valid}, 2'b10);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule